// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write command into the column address sequence that a synchronous DRAM-style memory walks through during a burst. The controller presents the starting column together with the programmed burst-length code, the ordering choice (sequential or interleaved) and the write-length option. The block then drives one column address per clock for as long as the burst lasts.

Full-column bursts are also supported. They do not end on their own: they keep going until a stop command ends them. A low clock-enable freezes the sequence. While frozen, a read repeats the same column, and a write beat is marked as not to be taken. On the final beat of a fixed-length burst the block raises a one-cycle flag. When auto-precharge was asked for and is legal, it raises a precharge-start pulse on that same beat.

Top module: `burst_col_gen`

## Requirements
- R1: Burst-length codes on `bl_code` are 0→1, 1→2, 2→4, 3→8 and 7→full column (256). Codes 4 to 6 act as length 1. Sequential order adds one per beat and wraps to the lowest column of the aligned block of the burst length, so the bits above the block stay those of the start column.
- R2: With `ilv_req`=1 and a fixed length L, each beat's low log2(L) column bits are the start column's low bits XOR the beat index (0,1,2,...), and the upper bits stay unchanged.
- R3: A full-column burst ignores `ilv_req` and counts sequentially over all 256 columns, wrapping from 255 to 0. It never raises `last_beat`. It runs until `stop` is sampled high with `cke`=1, after which `busy` is low on the next cycle.
- R4: With `single_wr`=1, every write is one beat long whatever the length code. Reads keep the programmed length.
- R5: A command accepted at a clock edge shows its start column on `col_addr`, with `busy`=1 and `beat_live`=1, in the cycle that follows. Without suspend, a new column follows on each later cycle.
- R6: `last_beat` is high for exactly the one cycle holding the final live beat of a fixed-length burst. `busy` is low in the next cycle unless a new command was accepted.
- R7: `apre_go` pulses together with `last_beat` when the command carried `cmd_apre`=1 and the burst is not full-column. That is the cycle L clocks after the command edge. Full-column bursts never pulse `apre_go`, but a single-write write may.
- R8: When `cke`=0 is sampled at an edge while `busy`=1, the next cycle keeps the same `col_addr` and `busy`, and shows `beat_live`=0. The sequence resumes from that column once `cke` returns high.
- R9: `cmd_valid` and `stop` have no effect when sampled with `cke`=0.
- R10: A command accepted during an active burst restarts the generator, so the next cycle carries the new start column.
- R11: Synchronous active-low reset leaves `busy`, `beat_live`, `last_beat` and `apre_go` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends the burst and blocks commands |
| cmd_valid | input | 1 | Read or write command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_apre | input | 1 | Auto-precharge requested with the command |
| cmd_col | input | 8 | Starting column |
| bl_code | input | 3 | Programmed burst-length code |
| ilv_req | input | 1 | 1 = interleaved order, 0 = sequential |
| single_wr | input | 1 | 1 = writes are always one beat |
| stop | input | 1 | Burst-stop command |
| col_addr | output | 8 | Current column address |
| busy | output | 1 | A burst is in progress |
| beat_live | output | 1 | The current beat is a fresh (non-repeated) beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| apre_go | output | 1 | Start auto-precharge |
| burst_wr | output | 1 | The active burst is a write |

## Verification
The bench walks bursts whose start column sits near the top of its aligned block. A generator that carried into the upper bits instead of wrapping would leave the block there. It also runs interleaved bursts from odd offsets, where an adder in place of the XOR gives a visibly wrong order.

A full-column burst is started just below column 255 with interleave and auto-precharge requested. A design that honoured either request, or stopped at 8 beats, would be caught. Further checks cover:
- a suspend in mid-read, which a design would fail by advancing or dropping the beat;
- a command offered during suspend, which must be ignored;
- a single-write write against a read in the same mode, where the lengths must differ;
- a restart in mid-burst, which must switch columns on the very next cycle.

// File: rtl/burst_col_pkg.sv
// Package: shared codes and mode record for the burst column generator.
// Assumes an 8-bit column space by default; codes are fixed by the command format.
package burst_col_pkg;
    localparam logic [2:0] BL_CODE_FULL = 3'd7;   // full-column burst code

    typedef struct packed {
        logic full;   // full-column burst, unbounded
        logic ilv;    // interleaved order in effect
        logic wr;     // burst is a write
        logic apre;   // auto-precharge legal and requested
    } burst_mode_t;
endpackage

// File: rtl/burst_len_decode.sv
// Module: burst_len_decode
// Turns the length code, direction and options into a counting mask and a mode
// record. Assumes MAX_LOG < COL_W; codes above MAX_LOG other than full act as 1.
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int unsigned COL_W   = 8,
    parameter int unsigned MAX_LOG = 3
) (
    input  logic [2:0]       bl_code,
    input  logic             is_write,
    input  logic             single_wr,
    input  logic             ilv_req,
    input  logic             apre_req,
    output logic [COL_W-1:0] len_mask,
    output burst_mode_t      mode
);
    logic code_full;
    logic force_one;
    logic code_fixed;

    // Classify the code and the single-write override.
    always_comb begin
        force_one  = is_write && single_wr;
        code_full  = (bl_code == BL_CODE_FULL) && !force_one;
        code_fixed = (int'(bl_code) <= int'(MAX_LOG)) && !force_one;
    end

    // One mask bit per column bit: set when the bit counts inside the burst block.
    for (genvar b = 0; b < COL_W; b++) begin : g_mask
        always_comb begin
            if (code_full)
                len_mask[b] = 1'b1;
            else if (code_fixed)
                len_mask[b] = (int'(bl_code) > b);
            else
                len_mask[b] = 1'b0;
        end
    end

    // Build the mode record; full column forces sequential order and drops precharge.
    always_comb begin
        mode.full = code_full;
        mode.ilv  = ilv_req && !code_full;
        mode.wr   = is_write;
        mode.apre = apre_req && !code_full;
    end
endmodule

// File: rtl/burst_order_unit.sv
// Module: burst_order_unit
// Forms the column for a given beat index from the start column and counting mask.
// Assumes the beat index never exceeds the mask (the sequencer guarantees it).
module burst_order_unit #(
    parameter int unsigned COL_W = 8
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] len_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;

    // Linear sum; bits outside the mask are discarded below, so carries never escape.
    always_comb seq_sum = start_col + beat_idx;

    // Per-bit selection between kept upper bit, wrapped sum and XOR order.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!len_mask[b])
                col[b] = start_col[b];
            else if (ilv)
                col[b] = start_col[b] ^ beat_idx[b];
            else
                col[b] = seq_sum[b];
        end
    end
endmodule

// File: rtl/burst_seq_ctrl.sv
// Module: burst_seq_ctrl
// Holds the burst state: start column, beat counter, mask and mode. Advances one
// beat per enabled clock, honours suspend, stop and restart.
// Assumes commands and stop are only meaningful with cke high.
module burst_seq_ctrl
    import burst_col_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [COL_W-1:0] dec_mask,
    input  burst_mode_t      dec_mode,
    input  logic             stop,
    output logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] len_mask,
    output burst_mode_t      mode,
    output logic             active,
    output logic             live,
    output logic             at_end
);
    // The final beat of a fixed burst: counter has reached the mask.
    always_comb at_end = active && !mode.full && (beat_idx == len_mask);

    // State update: load on command, step, finish, stop or hold under suspend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_col <= '0;
            beat_idx  <= '0;
            len_mask  <= '0;
            mode      <= '0;
            active    <= 1'b0;
            live      <= 1'b0;
        end else if (!cke) begin
            live <= 1'b0;
        end else if (cmd_valid) begin
            start_col <= cmd_col;
            beat_idx  <= '0;
            len_mask  <= dec_mask;
            mode      <= dec_mode;
            active    <= 1'b1;
            live      <= 1'b1;
        end else if (active && (stop || at_end)) begin
            active <= 1'b0;
            live   <= 1'b0;
        end else if (active) begin
            beat_idx <= beat_idx + COL_W'(1);
            live     <= 1'b1;
        end else begin
            live <= 1'b0;
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Column address sequencer for synchronous DRAM bursts: decodes the command,
// sequences beats and forms each column in sequential or interleaved order.
// Assumes a controller that issues commands only on valid cycles and gates data
// with beat_live.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int unsigned COL_W   = 8,
    parameter int unsigned MAX_LOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic             cmd_apre,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       bl_code,
    input  logic             ilv_req,
    input  logic             single_wr,
    input  logic             stop,
    output logic [COL_W-1:0] col_addr,
    output logic             busy,
    output logic             beat_live,
    output logic             last_beat,
    output logic             apre_go,
    output logic             burst_wr
);
    logic [COL_W-1:0] dec_mask;
    burst_mode_t      dec_mode;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] len_mask;
    burst_mode_t      mode;
    logic             active;
    logic             live;
    logic             at_end;

    burst_len_decode #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_dec (
        .bl_code   (bl_code),
        .is_write  (cmd_write),
        .single_wr (single_wr),
        .ilv_req   (ilv_req),
        .apre_req  (cmd_apre),
        .len_mask  (dec_mask),
        .mode      (dec_mode)
    );

    burst_seq_ctrl #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .cmd_valid (cmd_valid),
        .cmd_col   (cmd_col),
        .dec_mask  (dec_mask),
        .dec_mode  (dec_mode),
        .stop      (stop),
        .start_col (start_col),
        .beat_idx  (beat_idx),
        .len_mask  (len_mask),
        .mode      (mode),
        .active    (active),
        .live      (live),
        .at_end    (at_end)
    );

    burst_order_unit #(.COL_W(COL_W)) u_ord (
        .start_col (start_col),
        .beat_idx  (beat_idx),
        .len_mask  (len_mask),
        .ilv       (mode.ilv),
        .col       (col_addr)
    );

    // Output flags derived from the registered state.
    always_comb begin
        busy      = active;
        beat_live = active && live;
        last_beat = at_end && live;
        apre_go   = at_end && live && mode.apre;
        burst_wr  = active && mode.wr;
    end
endmodule

// File: rtl/burst_col_gen_chk.sv
// Module: burst_col_gen_chk
// Temporal checks on the generator's ports, bound to every burst_col_gen instance.
module burst_col_gen_chk #(
    parameter int unsigned COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cmd_valid,
    input logic             stop,
    input logic [COL_W-1:0] cmd_col,
    input logic [COL_W-1:0] col_addr,
    input logic             busy,
    input logic             beat_live,
    input logic             last_beat,
    input logic             apre_go
);
    // R5
    start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cmd_valid) |=> (busy && beat_live && col_addr == $past(cmd_col)));

    // R8
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cke) |=> (busy && !beat_live && $stable(col_addr)));

    // R3
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cke && stop && !cmd_valid) |=> !busy);

    // R6
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && cke && !cmd_valid) |=> !busy);

    // R6
    last_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> (busy && beat_live));

    // R7
    apre_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apre_go |-> last_beat);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cke && cmd_valid)) |=> !busy);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cmd_valid (cmd_valid),
    .stop      (stop),
    .cmd_col   (cmd_col),
    .col_addr  (col_addr),
    .busy      (busy),
    .beat_live (beat_live),
    .last_beat (last_beat),
    .apre_go   (apre_go)
);

// File: tb/burst_col_gen_tb_top.sv
// Bench for burst_col_gen: a vector table walked by one loop, then directed cases.
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic       cmd_apre = 1'b0;
    logic [7:0] cmd_col = '0;
    logic [2:0] bl_code = '0;
    logic       ilv_req = 1'b0;
    logic       single_wr = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col_addr;
    logic       busy, beat_live, last_beat, apre_go, burst_wr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_valid(cmd_valid),
        .cmd_write(cmd_write), .cmd_apre(cmd_apre), .cmd_col(cmd_col),
        .bl_code(bl_code), .ilv_req(ilv_req), .single_wr(single_wr), .stop(stop),
        .col_addr(col_addr), .busy(busy), .beat_live(beat_live),
        .last_beat(last_beat), .apre_go(apre_go), .burst_wr(burst_wr)
    );

    // {apre, write, single_wr, ilv, bl_code[2:0], col[7:0]}
    localparam logic [14:0] VEC [10] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 8'h05},  // R1 wrap in block of 4
        {1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 8'h05},  // R2
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 8'h1E},  // R1 block of 8
        {1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 8'h1E},  // R2
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'h33},  // R1 length 2
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h40},  // R1 length 1
        {1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 8'h21},  // R4 single write
        {1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 8'h22},  // R4 read keeps length
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 8'h7F},  // R1 write burst
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 8'h10}   // R1 reserved code
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int blen(input int code, input bit swr, input bit wr);
        if (swr && wr) return 1;
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int col, input int len, input bit ilv, input int i);
        int base, off;
        base = (col / len) * len;
        off  = col % len;
        if (ilv && len != 256) return base + (off ^ i);
        return base + ((off + i) % len);
    endfunction

    // Present a command at a falling edge; it is taken at the next rising edge.
    task automatic issue(input bit apre, input bit wr, input bit swr, input bit ilv,
                         input logic [2:0] code, input logic [7:0] col);
        cmd_valid = 1'b1; cmd_apre = apre; cmd_write = wr;
        single_wr = swr; ilv_req = ilv; bl_code = code; cmd_col = col;
    endtask

    int watchdog = 0;
    always @(posedge clk) begin
        watchdog++;
        if (watchdog == 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", watchdog, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !beat_live && !last_beat && !apre_go, "R11", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: every beat of each fixed burst (R1 R2 R4 R5 R6 R7)
        foreach (VEC[v]) begin
            int len;
            len = blen(int'(VEC[v][10:8]), VEC[v][12], VEC[v][13]);
            issue(VEC[v][14], VEC[v][13], VEC[v][12], VEC[v][11], VEC[v][10:8], VEC[v][7:0]);
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                cmd_valid = 1'b0;
                chk(busy && beat_live, "R5", busy, 1);
                chk(col_addr == 8'(exp_col(int'(VEC[v][7:0]), len, VEC[v][11], i)),
                    "R1/R2", col_addr, exp_col(int'(VEC[v][7:0]), len, VEC[v][11], i));
                chk(last_beat == (i == len - 1), "R6", last_beat, i == len - 1);
                chk(apre_go == (VEC[v][14] && i == len - 1), "R7", apre_go,
                    VEC[v][14] && i == len - 1);
                chk(burst_wr == VEC[v][13], "R4", burst_wr, VEC[v][13]);
            end
            @(negedge clk);
            chk(!busy, "R6", busy, 0);
        end

        // R3 full column: interleave and precharge requests ignored, wraps 255->0
        issue(1'b1, 1'b0, 1'b0, 1'b1, 3'd7, 8'hFD);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(col_addr == 8'((253 + i) % 256), "R3", col_addr, (253 + i) % 256);
            chk(busy && !last_beat && !apre_go, "R3", last_beat, 0);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!busy, "R3", busy, 0);

        // R4 R7 full-column code with single-write write: one beat, precharge allowed
        issue(1'b1, 1'b1, 1'b1, 1'b0, 3'd7, 8'h9A);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(col_addr == 8'h9A && last_beat && apre_go, "R7", apre_go, 1);
        @(negedge clk);
        chk(!busy, "R4", busy, 0);
        single_wr = 1'b0;

        // R8 suspend during a read of 4 from column 8
        issue(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 8'h08);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(col_addr == 8'h08 && beat_live, "R8", col_addr, 8);
        cke = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(busy && !beat_live && col_addr == 8'h08, "R8", col_addr, 8);
        end
        cke = 1'b1;
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            chk(beat_live && col_addr == 8'(8 + i), "R8", col_addr, 8 + i);
        end
        chk(last_beat, "R8", last_beat, 1);
        @(negedge clk);
        chk(!busy, "R8", busy, 0);

        // R8 suspended write beat is marked not live
        issue(1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 8'h60);
        @(negedge clk);
        cmd_valid = 1'b0;
        cke = 1'b0;
        @(negedge clk);
        chk(burst_wr && !beat_live && col_addr == 8'h60, "R8", beat_live, 0);
        cke = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy, "R8", busy, 0);

        // R9 command with cke low is ignored
        cke = 1'b0;
        issue(1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 8'h11);
        @(negedge clk);
        cmd_valid = 1'b0;
        cke = 1'b1;
        @(negedge clk);
        chk(!busy, "R9", busy, 0);

        // R9 stop with cke low does not end a full-column burst
        issue(1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 8'h00);
        @(negedge clk);
        cmd_valid = 1'b0;
        cke = 1'b0; stop = 1'b1;
        @(negedge clk);
        cke = 1'b1; stop = 1'b0;
        @(negedge clk);
        chk(busy && col_addr == 8'h01, "R9", col_addr, 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!busy, "R3", busy, 0);

        // R10 restart in mid-burst
        issue(1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 8'h50);
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(col_addr == 8'h51, "R10", col_addr, 8'h51);
        issue(1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 8'h90);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(col_addr == 8'h90 && beat_live, "R10", col_addr, 8'h90);
        repeat (3) @(negedge clk);
        chk(last_beat && col_addr == 8'h93, "R10", col_addr, 8'h93);
        @(negedge clk);

        // R11 reset in mid-burst returns to idle
        issue(1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 8'h00);
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !beat_live, "R11", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule